// File: doc/BRIEF.md
# Code Protection and Verify Unit

This block sits beside an on-chip program memory model and decides what a programming or verify access may do. It keeps a 64-byte scrambling key array and three lock bits. A verify of a code location returns the raw byte from the array, bitwise XNORed with the key byte that the low six address bits select. An erased key array is all ones, so a verify then returns the code unchanged. Signature reads return fixed identification bytes.

Programming is paced by falling edges of a program strobe. A code location commits after a short run of strobe falls. A key byte or a lock bit needs a longer run. The lock bits are cumulative. The first one blocks further code and key programming, stops table reads running from external memory from fetching internal code, and tells the CPU to latch its external-access strap at reset. Adding the second one also stops code verify. Adding the third one also forbids external execution. Lock bits are never read back. Their state shows only through the permission outputs and the refusals.

Top module: `cpv_unit`

## Requirements
- R1: After reset every key byte is 0xFF and every lock bit is unprogrammed. `int_fetch_ok` and `ext_exec_ok` are high, `ea_latch_en`, `err`, `verify_valid` and `code_wr` are low, and a code verify returns `code_in` unchanged.
- R2: When `verify_req` is high at a clock edge, `verify_valid` is high for the following cycle. In code mode (`mode_sel`=0) `verify_out` then holds `code_in` XNOR key[`addr[5:0]`].
- R3: A code verify of the byte 0xFF returns the selected key byte itself.
- R4: In code mode with `prog_en` high, `code_wr` pulses for one cycle on the 5th falling edge of `prog_strobe`, and not on any earlier edge.
- R5: In key mode (`mode_sel`=1) the 25th strobe fall stores key[`addr[5:0]`] AND `prog_data`, so bits only go from 1 to 0. Twenty-four falls change nothing.
- R6: Lock bit 1 (`mode_sel`=2, 25 falls) drives `int_fetch_ok` low and `ea_latch_en` high. After that, each strobe fall in code or key mode is refused: `err` goes high for one cycle and nothing commits. Lock programming stays allowed.
- R7: With lock bits 1 and 2 both programmed (lock 2 is `mode_sel`=3), a code verify is refused. `verify_out` is 0xFF and `err` is high in the cycle where `verify_valid` is high.
- R8: With all three lock bits programmed (lock 3 is `mode_sel`=4), `ext_exec_ok` is low. `ext_exec_ok` low always implies `int_fetch_ok` low.
- R9: A verify in key mode or in any lock mode returns 0xFF with `err` high, so neither the key array nor the lock bits can be read.
- R10: A verify in signature mode (`mode_sel`=5) is always allowed and depends on `addr[7:0]`: 0x30 gives 0x89, 0x31 gives 0x58, 0x60 gives the device byte (default 0x51), and any other value gives 0xFF.
- R11: The strobe count restarts when `addr` or `mode_sel` changes or `prog_en` goes low. A run that is split by a change needs the full count again after the change.
- R12: `erase` sets every key byte to 0xFF and every lock bit to unprogrammed in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the access |
| mode_sel | input | 3 | 0 code, 1 key array, 2/3/4 lock bit 1/2/3, 5 signature |
| code_in | input | 8 | Raw code byte read from the array |
| prog_data | input | 8 | Byte to program |
| prog_en | input | 1 | Program request, held high for the whole strobe run |
| prog_strobe | input | 1 | Program strobe; falling edges are counted |
| verify_req | input | 1 | Verify request |
| erase | input | 1 | Restore key array and lock bits to ones |
| verify_out | output | 8 | Verify or signature byte |
| verify_valid | output | 1 | `verify_out` is valid this cycle |
| err | output | 1 | Refused request, one cycle |
| code_wr | output | 1 | Commit pulse for a code location |
| int_fetch_ok | output | 1 | Table reads from external code may fetch internal bytes |
| ext_exec_ok | output | 1 | External execution allowed |
| ea_latch_en | output | 1 | Latch the external-access strap at reset |

## Verification
A verify result, together with its `err`, appears in the cycle after the edge that sampled `verify_req`. The bench raises the request on a falling clock edge and reads the result on the next falling edge. A strobe fall is seen at the first rising edge where the strobe input is low. The `code_wr` or `err` pulse it causes, and any key or lock update, become visible in the cycle after that edge. The bench therefore samples them on the falling edge that follows each low strobe phase. Permission outputs are read at least one cycle after the commit that changes them. After every address or mode change the bench waits one cycle before it starts strobing.

// File: rtl/cpv_pkg.sv
package cpv_pkg;
  localparam logic [2:0] MD_CODE = 3'd0;
  localparam logic [2:0] MD_KEY  = 3'd1;
  localparam logic [2:0] MD_LK1  = 3'd2;
  localparam logic [2:0] MD_LK2  = 3'd3;
  localparam logic [2:0] MD_LK3  = 3'd4;
  localparam logic [2:0] MD_SIG  = 3'd5;

  // identification byte for a signature address
  function automatic logic [7:0] sig_lookup(input logic [7:0] a, input logic [7:0] dev);
    case (a)
      8'h30:   sig_lookup = 8'h89;
      8'h31:   sig_lookup = 8'h58;
      8'h60:   sig_lookup = dev;
      default: sig_lookup = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/cpv_pulse_cnt.sv
module cpv_pulse_cnt #(
  parameter int ADDR_W      = 12,
  parameter int CODE_PULSES = 5,
  parameter int KEY_PULSES  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        mode,
  input  logic              prog_en,
  input  logic              prog_strobe,
  input  logic              refused,
  output logic              hit,
  output logic              prog_err
);
  import cpv_pkg::*;
  localparam int MAXP  = (CODE_PULSES > KEY_PULSES) ? CODE_PULSES : KEY_PULSES;
  localparam int CNT_W = $clog2(MAXP + 1);

  logic              strb_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        mode_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d, target;
  logic              fall, clr, step;

  always_comb begin
    target   = (mode == MD_CODE) ? CNT_W'(CODE_PULSES) : CNT_W'(KEY_PULSES);
    fall     = strb_q & ~prog_strobe & prog_en;
    clr      = ~prog_en | (addr != addr_q) | (mode != mode_q);
    step     = fall & ~refused & ~clr & (cnt_q < target);
    hit      = step & (cnt_q == target - 1'b1);
    prog_err = fall & refused;
    cnt_d    = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b1;
      addr_q <= '0;
      mode_q <= MD_CODE;
      cnt_q  <= '0;
    end else begin
      strb_q <= prog_strobe;
      addr_q <= addr;
      mode_q <= mode;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/cpv_key_store.sv
module cpv_key_store #(
  parameter int KEY_DEPTH = 64,
  parameter int KEY_AW    = $clog2(KEY_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              key_we,
  input  logic [KEY_AW-1:0] key_idx,
  input  logic [7:0]        key_wdata,
  input  logic [2:0]        lock_we,
  output logic [7:0]        key_byte,
  output logic [2:0]        lock_n
);
  logic [KEY_DEPTH-1:0][7:0] key_q, key_d;
  logic [2:0]                lock_q, lock_d;

  always_comb begin
    key_d  = key_q;
    lock_d = lock_q;
    if (erase) begin
      key_d  = '1;
      lock_d = '1;
    end else begin
      if (key_we) key_d[key_idx] = key_q[key_idx] & key_wdata;
      lock_d = lock_q & ~lock_we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '1;
      lock_q <= '1;
    end else begin
      key_q  <= key_d;
      lock_q <= lock_d;
    end
  end

  assign key_byte = key_q[key_idx];
  assign lock_n   = lock_q;
endmodule

// File: rtl/cpv_verify.sv
module cpv_verify #(
  parameter logic [7:0] SIG_DEV = 8'h51
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [2:0] mode,
  input  logic [7:0] addr_lo,
  input  logic [7:0] code_in,
  input  logic [7:0] key_byte,
  input  logic       verify_off,
  output logic [7:0] out_q,
  output logic       valid_q,
  output logic       ver_err
);
  import cpv_pkg::*;
  logic [7:0] out_d;

  always_comb begin
    ver_err = 1'b0;
    out_d   = out_q;
    if (req) begin
      if (mode == MD_SIG) begin
        out_d = sig_lookup(addr_lo, SIG_DEV);
      end else if (mode == MD_CODE && !verify_off) begin
        out_d = ~(code_in ^ key_byte);
      end else begin
        out_d   = 8'hFF;
        ver_err = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= 8'hFF;
      valid_q <= 1'b0;
    end else begin
      out_q   <= out_d;
      valid_q <= req;
    end
  end
endmodule

// File: rtl/cpv_unit.sv
module cpv_unit #(
  parameter int         ADDR_W      = 12,
  parameter int         KEY_DEPTH   = 64,
  parameter int         CODE_PULSES = 5,
  parameter int         KEY_PULSES  = 25,
  parameter logic [7:0] SIG_DEV     = 8'h51
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        mode_sel,
  input  logic [7:0]        code_in,
  input  logic [7:0]        prog_data,
  input  logic              prog_en,
  input  logic              prog_strobe,
  input  logic              verify_req,
  input  logic              erase,
  output logic [7:0]        verify_out,
  output logic              verify_valid,
  output logic              err,
  output logic              code_wr,
  output logic              int_fetch_ok,
  output logic              ext_exec_ok,
  output logic              ea_latch_en
);
  import cpv_pkg::*;
  localparam int KEY_AW = $clog2(KEY_DEPTH);

  logic [2:0] lock_n, lock_we;
  logic [7:0] key_byte;
  logic       hit, prog_err, ver_err, refused, key_we;
  logic       lock1_on, verify_off, exec_off;
  logic       err_q, wr_q;

  always_comb begin
    lock1_on   = ~lock_n[0];
    verify_off = ~lock_n[0] & ~lock_n[1];
    exec_off   = ~(|lock_n);
    refused    = (lock1_on & (mode_sel == MD_CODE || mode_sel == MD_KEY))
               | (mode_sel >= MD_SIG);
    key_we     = hit & (mode_sel == MD_KEY);
    lock_we    = {3{hit}} & {mode_sel == MD_LK3, mode_sel == MD_LK2, mode_sel == MD_LK1};
  end

  cpv_pulse_cnt #(.ADDR_W(ADDR_W), .CODE_PULSES(CODE_PULSES), .KEY_PULSES(KEY_PULSES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mode(mode_sel), .prog_en(prog_en),
    .prog_strobe(prog_strobe), .refused(refused), .hit(hit), .prog_err(prog_err)
  );

  cpv_key_store #(.KEY_DEPTH(KEY_DEPTH), .KEY_AW(KEY_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .erase(erase), .key_we(key_we),
    .key_idx(addr[KEY_AW-1:0]), .key_wdata(prog_data), .lock_we(lock_we),
    .key_byte(key_byte), .lock_n(lock_n)
  );

  cpv_verify #(.SIG_DEV(SIG_DEV)) u_ver (
    .clk(clk), .rst_n(rst_n), .req(verify_req), .mode(mode_sel), .addr_lo(addr[7:0]),
    .code_in(code_in), .key_byte(key_byte), .verify_off(verify_off),
    .out_q(verify_out), .valid_q(verify_valid), .ver_err(ver_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      err_q <= prog_err | ver_err;
      wr_q  <= hit & (mode_sel == MD_CODE);
    end
  end

  assign err          = err_q;
  assign code_wr      = wr_q;
  assign int_fetch_ok = ~lock1_on;
  assign ea_latch_en  = lock1_on;
  assign ext_exec_ok  = ~exec_off;
endmodule

// File: rtl/cpv_chk.sv
module cpv_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [2:0]        mode_sel,
  input logic              verify_req,
  input logic              erase,
  input logic [7:0]        verify_out,
  input logic              verify_valid,
  input logic              err,
  input logic              code_wr,
  input logic              int_fetch_ok,
  input logic              ext_exec_ok
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    verify_req |=> verify_valid); // R2
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !verify_req |=> !verify_valid); // R2
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    code_wr |=> !code_wr); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_fetch_ok && !erase) |=> !int_fetch_ok); // R6
  AST_EXEC_CUMUL: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_exec_ok |-> !int_fetch_ok); // R8
  AST_HIDDEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (verify_req && mode_sel >= 3'd1 && mode_sel <= 3'd4) |=> (verify_out == 8'hFF && err)); // R9
  AST_SIG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (verify_req && mode_sel == 3'd5 && addr[7:0] == 8'h30) |=> verify_out == 8'h89); // R10
  AST_ERASE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (int_fetch_ok && ext_exec_ok)); // R12
endmodule

bind cpv_unit cpv_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .mode_sel(mode_sel), .verify_req(verify_req),
  .erase(erase), .verify_out(verify_out), .verify_valid(verify_valid), .err(err),
  .code_wr(code_wr), .int_fetch_ok(int_fetch_ok), .ext_exec_ok(ext_exec_ok)
);

// File: tb/sim_cpv_unit.sv
`timescale 1ns/1ps
module sim_cpv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [2:0]  mode_sel = 3'd0;
  logic [7:0]  code_in = '0, prog_data = '0;
  logic        prog_en = 1'b0, prog_strobe = 1'b1, verify_req = 1'b0, erase = 1'b0;
  logic [7:0]  verify_out;
  logic        verify_valid, err, code_wr, int_fetch_ok, ext_exec_ok, ea_latch_en;

  int total = 0, bad = 0, n_wr = 0, n_err = 0;
  logic        done = 1'b0;
  logic [7:0]  mdl_key [64];
  logic [7:0]  v_out;
  logic        v_ok, v_err;

  always #5 clk = ~clk;

  cpv_unit u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mode_sel(mode_sel), .code_in(code_in),
    .prog_data(prog_data), .prog_en(prog_en), .prog_strobe(prog_strobe),
    .verify_req(verify_req), .erase(erase), .verify_out(verify_out),
    .verify_valid(verify_valid), .err(err), .code_wr(code_wr),
    .int_fetch_ok(int_fetch_ok), .ext_exec_ok(ext_exec_ok), .ea_latch_en(ea_latch_en)
  );

  function automatic logic [7:0] exp_code(input logic [7:0] c, input logic [7:0] k);
    return ~(c ^ k);
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_verify(input logic [2:0] m, input logic [11:0] a, input logic [7:0] c);
    @(negedge clk);
    mode_sel = m; addr = a; code_in = c; verify_req = 1'b1;
    @(negedge clk);
    v_out = verify_out; v_ok = verify_valid; v_err = err;
    verify_req = 1'b0;
  endtask

  task automatic prog_start(input logic [2:0] m, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    mode_sel = m; addr = a; prog_data = d; prog_en = 1'b1;
    n_wr = 0; n_err = 0;
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      prog_strobe = 1'b0;
      @(negedge clk);
      if (code_wr) n_wr++;
      if (err) n_err++;
      prog_strobe = 1'b1;
    end
  endtask

  task automatic prog_stop;
    @(negedge clk);
    prog_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic prog_key(input logic [11:0] a, input logic [7:0] d);
    prog_start(3'd1, a, d);
    pulses(25);
    prog_stop();
    mdl_key[a[5:0]] = mdl_key[a[5:0]] & d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 64; i++) mdl_key[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 int_fetch_ok", int_fetch_ok, 1);
    chk("R1 ext_exec_ok", ext_exec_ok, 1);
    chk("R1 ea_latch_en", ea_latch_en, 0);
    chk("R1 err", err, 0);
    chk("R1 verify_valid", verify_valid, 0);
    chk("R1 code_wr", code_wr, 0);
    for (int i = 0; i < 20; i++) begin
      logic [7:0]  c = 8'($urandom);
      logic [11:0] a = 12'($urandom);
      do_verify(3'd0, a, c);
      chk("R1 erased key passes code", v_out, c);
      chk("R2 valid", v_ok, 1);
    end
    // R5 24 falls do nothing, prog_en drop restarts (R11)
    prog_start(3'd1, 12'h005, 8'h3C);
    pulses(24);
    prog_stop();
    do_verify(3'd0, 12'h045, 8'hFF);
    chk("R5 no commit at 24", v_out, 8'hFF);
    prog_key(12'h005, 8'h3C);
    do_verify(3'd0, 12'h045, 8'hFF);
    chk("R3 ff returns key", v_out, 8'h3C);
    prog_key(12'h085, 8'hF0);
    do_verify(3'd0, 12'h005, 8'hFF);
    chk("R5 and-only update", v_out, 8'h30);
    // random key programming and verify
    for (int i = 0; i < 6; i++) prog_key(12'($urandom), 8'($urandom));
    for (int i = 0; i < 40; i++) begin
      logic [7:0]  c = 8'($urandom);
      logic [11:0] a = 12'($urandom);
      do_verify(3'd0, a, c);
      chk("R2 verify xnor", v_out, exp_code(c, mdl_key[a[5:0]]));
      chk("R2 no err", v_err, 0);
    end
    // R4 code pulse count
    prog_start(3'd0, 12'h123, 8'h00);
    pulses(4);
    chk("R4 no wr before 5", n_wr, 0);
    pulses(1);
    chk("R4 wr at 5", n_wr, 1);
    pulses(3);
    chk("R4 single wr", n_wr, 1);
    prog_stop();
    // R11 address change restarts count
    prog_start(3'd0, 12'h200, 8'h00);
    pulses(3);
    @(negedge clk); addr = 12'h201;
    @(negedge clk);
    pulses(2);
    chk("R11 no wr after split", n_wr, 0);
    pulses(3);
    chk("R11 wr after full run", n_wr, 1);
    prog_stop();
    // R9 hidden state
    for (int m = 1; m <= 4; m++) begin
      do_verify(3'(m), 12'h005, 8'h00);
      chk("R9 hidden out", v_out, 8'hFF);
      chk("R9 hidden err", v_err, 1);
    end
    // R10 signatures
    do_verify(3'd5, 12'h030, 8'h00); chk("R10 sig 30", v_out, 8'h89);
    do_verify(3'd5, 12'h031, 8'h00); chk("R10 sig 31", v_out, 8'h58);
    do_verify(3'd5, 12'h060, 8'h00); chk("R10 sig 60", v_out, 8'h51);
    do_verify(3'd5, 12'h061, 8'h00); chk("R10 sig other", v_out, 8'hFF);
    chk("R10 sig no err", v_err, 0);
    // R6 lock 1
    prog_start(3'd2, 12'h000, 8'h00); pulses(25); prog_stop();
    chk("R6 int_fetch_ok", int_fetch_ok, 0);
    chk("R6 ea_latch_en", ea_latch_en, 1);
    chk("R6 ext_exec_ok", ext_exec_ok, 1);
    prog_start(3'd0, 12'h010, 8'h00); pulses(5);
    chk("R6 code refused wr", n_wr, 0);
    chk("R6 code refused err", n_err, 5);
    prog_stop();
    prog_start(3'd1, 12'h005, 8'h00); pulses(25); prog_stop();
    chk("R6 key refused err", n_err, 25);
    do_verify(3'd0, 12'h005, 8'hFF);
    chk("R6 key unchanged", v_out, mdl_key[5]);
    // R7 lock 2
    prog_start(3'd3, 12'h000, 8'h00); pulses(25); prog_stop();
    do_verify(3'd0, 12'h005, 8'h12);
    chk("R7 verify out", v_out, 8'hFF);
    chk("R7 verify err", v_err, 1);
    chk("R7 valid", v_ok, 1);
    chk("R7 exec still ok", ext_exec_ok, 1);
    do_verify(3'd5, 12'h031, 8'h00); chk("R10 sig under lock", v_out, 8'h58);
    // R8 lock 3
    prog_start(3'd4, 12'h000, 8'h00); pulses(25); prog_stop();
    chk("R8 ext_exec_ok", ext_exec_ok, 0);
    chk("R8 int_fetch_ok", int_fetch_ok, 0);
    // R12 erase
    @(negedge clk); erase = 1'b1;
    @(negedge clk); erase = 1'b0;
    for (int i = 0; i < 64; i++) mdl_key[i] = 8'hFF;
    chk("R12 int_fetch_ok", int_fetch_ok, 1);
    chk("R12 ext_exec_ok", ext_exec_ok, 1);
    chk("R12 ea_latch_en", ea_latch_en, 0);
    do_verify(3'd0, 12'h005, 8'h5A);
    chk("R12 key erased", v_out, 8'h5A);
    prog_start(3'd0, 12'h010, 8'h00); pulses(5);
    chk("R12 code prog open", n_wr, 1);
    prog_stop();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule